// File: doc/BRIEF.md
# Paged Switch Register Access Bridge over MDIO

This block lets a host reach the 32-bit registers of an Ethernet switch that only has a 16-bit MDIO management port. A request gives an operation, a switch register address and, for writes, data. The block turns each request into a series of MDIO commands. First it writes the upper address bits to a page register. Then it moves the two 16-bit halves of the register through a PHY address and register number that it derives from the middle and low address bits.

The block also tunnels accesses to the PHYs behind the switch. It does this through a mailbox held in switch register 0x98. It reads the mailbox once and discards the value. It then writes a command word with the start/busy bit set. After that it reads the mailbox again and again until the busy bit clears, and returns the low half of the last read. If the busy bit never clears within the poll limit, the block gives up and flags a timeout.

The block takes one request at a time. It answers each request with a single acknowledge pulse. Each MDIO command goes to an external management controller as a one-cycle start. The block then waits for that controller's done pulse before it issues the next command.

Top module: `swbr_bridge`

## Requirements
- R1: Operation code 0 (register read) of address A issues three commands. The first is a write of A>>9 to PHY 0x18, register 0. The second is a read of PHY ((A>>6)&7)|0x10 at register (A>>1)&0x1e. The third is a read of the same PHY at that register number with bit 0 set. The result is {second read, first read}.
- R2: Operation code 1 (register write) of data D to address A, with A not equal to 0x98, issues the same page write. It then writes D[31:16] to register number |1 and then D[15:0] to register number |0.
- R3: A register write to address 0x98 sends the low half (register number |0) before the high half (|1).
- R4: Operation code 2 (PHY read) first does a full register read of 0x98 as in R1. It then does a register write of 0x98 as in R3. The command word has bits 31 and 30 set, bit 27 set, the PHY address in bits 25:21, the PHY register in bits 20:16 and zero in bits 15:0.
- R5: Operation code 3 (PHY write) uses the same sequence as R4. Its command word has bit 27 clear and the write data in bits 15:0.
- R6: After the command word, the block repeats full register reads of 0x98 until bit 31 of a read is clear. The result is then zero in bits 31:16 and the low half of that last read in bits 15:0.
- R7: If POLL_LIMIT poll reads in a row all show bit 31 set, the block acknowledges with the timeout flag high. It issues no further MDIO command.
- R8: Each request gets exactly one acknowledge, one cycle long. The ready output is high only while the block is idle, and a request presented while the block is not ready is ignored.
- R9: During and right after reset the block is ready, with no acknowledge and no MDIO start.
- R10: Every MDIO start is a one-cycle pulse. No new start is issued until the done pulse for the previous command has arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, taken when reqReady is high |
| reqOp | input | 2 | 0 register read, 1 register write, 2 PHY read, 3 PHY write |
| reqAddr | input | ADDR_W | Switch register byte address |
| reqData | input | 32 | Register write data; bits 15:0 are the PHY write data |
| reqPhyAddr | input | 5 | PHY address for tunnelled accesses |
| reqPhyReg | input | 5 | PHY register for tunnelled accesses |
| reqReady | output | 1 | Block idle and able to accept a request |
| ack | output | 1 | One-cycle completion pulse |
| rdData | output | 32 | Read result, valid with ack |
| timeoutErr | output | 1 | Poll limit reached, valid with ack |
| mdStart | output | 1 | One-cycle MDIO command start |
| mdWrite | output | 1 | MDIO command is a write |
| mdPhy | output | 5 | MDIO PHY address |
| mdReg | output | 5 | MDIO register number |
| mdWdata | output | 16 | MDIO write data |
| mdDone | input | 1 | MDIO command complete |
| mdRdata | input | 16 | MDIO read data, valid with mdDone |

## Verification
A wrong sequencing state shows up directly in the MDIO command log. A missing or extra page write, halves sent in the wrong order, or a mailbox phase that is skipped each changes the list of commands recorded for that request. The acknowledge also arrives after a different number of commands. A wrong half-select state corrupts rdData at the acknowledge of the same request. A poll counter that is off by one moves the timeout by one full poll of three commands, which changes the total command count checked at that acknowledge.

// File: rtl/swbr_pkg.sv
package swbr_pkg;

  localparam int HALF_W = 16;
  localparam int WORD_W = 32;
  localparam int MDIO_ID_W = 5;

  localparam logic [MDIO_ID_W-1:0] PAGE_PHY = 5'h18;
  localparam logic [MDIO_ID_W-1:0] PAGE_REG = 5'h00;
  localparam int MBOX_ADDR = 'h98;

  typedef enum logic [1:0] {
    OP_REG_RD = 2'd0,
    OP_REG_WR = 2'd1,
    OP_PHY_RD = 2'd2,
    OP_PHY_WR = 2'd3
  } opKind_t;

  typedef enum logic [1:0] {
    PH_REG   = 2'd0,
    PH_DUMMY = 2'd1,
    PH_MBOX  = 2'd2,
    PH_POLL  = 2'd3
  } phase_t;

  typedef enum logic [1:0] {
    ST_PAGE   = 2'd0,
    ST_FIRST  = 2'd1,
    ST_SECOND = 2'd2
  } step_t;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_ISSUE = 2'd1,
    S_WAIT  = 2'd2,
    S_DONE  = 2'd3
  } state_t;

  typedef struct packed {
    logic   load;
    logic   issue;
    logic   capture;
    logic   pollClr;
    logic   pollInc;
    phase_t phase;
    step_t  step;
  } bridgeCtl_t;

endpackage

// File: rtl/swbr_ctrl.sv
module swbr_ctrl
  import swbr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  opKind_t    reqOp,
  input  logic       mdDone,
  input  logic       hiBusy,
  input  logic       pollLast,
  output bridgeCtl_t ctl,
  output logic       reqReady,
  output logic       ack,
  output logic       timeoutErr
);

  state_t state;
  phase_t phaseQ;
  step_t  stepQ;
  logic   errQ;

  logic loadNow;
  logic doneNow;
  logic isPhyOp;

  assign isPhyOp = (reqOp == OP_PHY_RD) || (reqOp == OP_PHY_WR);
  assign loadNow = (state == S_IDLE) && reqValid;
  assign doneNow = (state == S_WAIT) && mdDone;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      phaseQ <= PH_REG;
      stepQ  <= ST_PAGE;
      errQ   <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          if (reqValid) begin
            phaseQ <= isPhyOp ? PH_DUMMY : PH_REG;
            stepQ  <= ST_PAGE;
            errQ   <= 1'b0;
            state  <= S_ISSUE;
          end
        end
        S_ISSUE: state <= S_WAIT;
        S_WAIT: begin
          if (mdDone) begin
            if (stepQ == ST_PAGE) begin
              stepQ <= ST_FIRST;
              state <= S_ISSUE;
            end else if (stepQ == ST_FIRST) begin
              stepQ <= ST_SECOND;
              state <= S_ISSUE;
            end else begin
              stepQ <= ST_PAGE;
              case (phaseQ)
                PH_REG: state <= S_DONE;
                PH_DUMMY: begin
                  phaseQ <= PH_MBOX;
                  state  <= S_ISSUE;
                end
                PH_MBOX: begin
                  phaseQ <= PH_POLL;
                  state  <= S_ISSUE;
                end
                default: begin
                  if (!hiBusy) begin
                    state <= S_DONE;
                  end else if (pollLast) begin
                    errQ  <= 1'b1;
                    state <= S_DONE;
                  end else begin
                    state <= S_ISSUE;
                  end
                end
              endcase
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.load    = loadNow;
    ctl.issue   = (state == S_ISSUE);
    ctl.capture = doneNow;
    ctl.pollClr = loadNow;
    ctl.pollInc = doneNow && (stepQ == ST_SECOND) && (phaseQ == PH_POLL) && hiBusy && !pollLast;
    ctl.phase   = phaseQ;
    ctl.step    = stepQ;
  end

  assign reqReady   = (state == S_IDLE);
  assign ack        = (state == S_DONE);
  assign timeoutErr = ack && errQ;

  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    ack |=> !ack) else $error("ack longer than one cycle"); // R8

  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    ctl.issue |=> !ctl.issue) else $error("back-to-back MDIO start"); // R10

  AST_ERR_AFTER_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    (ack && errQ) |-> $past(pollLast)) else $error("timeout before poll limit"); // R7

endmodule

// File: rtl/swbr_dp.sv
module swbr_dp
  import swbr_pkg::*;
#(
  parameter int ADDR_W     = 18,
  parameter int POLL_LIMIT = 1000
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  bridgeCtl_t            ctl,
  input  opKind_t               reqOp,
  input  logic [ADDR_W-1:0]     reqAddr,
  input  logic [WORD_W-1:0]     reqData,
  input  logic [MDIO_ID_W-1:0]  reqPhyAddr,
  input  logic [MDIO_ID_W-1:0]  reqPhyReg,
  input  logic [HALF_W-1:0]     mdRdata,
  output logic                  hiBusy,
  output logic                  pollLast,
  output logic                  mdStart,
  output logic                  mdWrite,
  output logic [MDIO_ID_W-1:0]  mdPhy,
  output logic [MDIO_ID_W-1:0]  mdReg,
  output logic [HALF_W-1:0]     mdWdata,
  output logic [WORD_W-1:0]     rdData
);

  localparam int CNT_W = $clog2(POLL_LIMIT + 1);
  localparam logic [ADDR_W-1:0] MBOX = ADDR_W'(MBOX_ADDR);
  localparam logic [CNT_W-1:0] LAST_POLL = CNT_W'(POLL_LIMIT - 1);

  opKind_t               opQ;
  logic [ADDR_W-1:0]     addrQ;
  logic [WORD_W-1:0]     dataQ;
  logic [MDIO_ID_W-1:0]  phyAQ;
  logic [MDIO_ID_W-1:0]  phyRQ;
  logic [HALF_W-1:0]     rdLow;
  logic [HALF_W-1:0]     rdHigh;
  logic [CNT_W-1:0]      pollCnt;

  logic [ADDR_W-1:0]     swAddr;
  logic                  swWrite;
  logic [WORD_W-1:0]     swData;
  logic [WORD_W-1:0]     mboxWord;
  logic                  swap;
  logic                  halfHigh;
  logic [ADDR_W-1:0]     pageBits;

  // Current switch access target, chosen by the sequencing phase
  always_comb begin
    mboxWord = {4'b1100, (opQ == OP_PHY_RD), 1'b0, phyAQ, phyRQ,
                (opQ == OP_PHY_WR) ? dataQ[HALF_W-1:0] : {HALF_W{1'b0}}};
    case (ctl.phase)
      PH_REG: begin
        swAddr  = addrQ;
        swWrite = (opQ == OP_REG_WR);
        swData  = dataQ;
      end
      PH_MBOX: begin
        swAddr  = MBOX;
        swWrite = 1'b1;
        swData  = mboxWord;
      end
      default: begin
        swAddr  = MBOX;
        swWrite = 1'b0;
        swData  = '0;
      end
    endcase
    swap     = (swAddr == MBOX);
    // reads: low then high; writes: high then low, except the mailbox
    halfHigh = (ctl.step == ST_SECOND) ^ (swWrite && !swap);
    pageBits = swAddr >> 9;
  end

  // MDIO command fields
  always_comb begin
    if (ctl.step == ST_PAGE) begin
      mdPhy   = PAGE_PHY;
      mdReg   = PAGE_REG;
      mdWrite = 1'b1;
      mdWdata = HALF_W'(pageBits);
    end else begin
      mdPhy   = {2'b10, swAddr[8:6]};
      mdReg   = {swAddr[5:2], halfHigh};
      mdWrite = swWrite;
      mdWdata = halfHigh ? swData[WORD_W-1:HALF_W] : swData[HALF_W-1:0];
    end
  end

  assign mdStart  = ctl.issue;
  assign hiBusy   = mdRdata[HALF_W-1];
  assign pollLast = (pollCnt == LAST_POLL);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opQ     <= OP_REG_RD;
      addrQ   <= '0;
      dataQ   <= '0;
      phyAQ   <= '0;
      phyRQ   <= '0;
      rdLow   <= '0;
      rdHigh  <= '0;
      pollCnt <= '0;
    end else begin
      if (ctl.load) begin
        opQ   <= reqOp;
        addrQ <= reqAddr;
        dataQ <= reqData;
        phyAQ <= reqPhyAddr;
        phyRQ <= reqPhyReg;
      end
      if (ctl.capture && !mdWrite) begin
        if (halfHigh) rdHigh <= mdRdata;
        else          rdLow  <= mdRdata;
      end
      if (ctl.pollClr)      pollCnt <= '0;
      else if (ctl.pollInc) pollCnt <= pollCnt + 1'b1;
    end
  end

  always_comb begin
    case (opQ)
      OP_REG_RD: rdData = {rdHigh, rdLow};
      OP_PHY_RD,
      OP_PHY_WR: rdData = {{HALF_W{1'b0}}, rdLow};
      default:   rdData = '0;
    endcase
  end

  AST_READ_HALF_PHY: assert property (@(posedge clk) disable iff (!rstN)
    (mdStart && !mdWrite) |-> (mdPhy[4:3] == 2'b10)) else $error("read outside half-word PHY range"); // R1

  AST_POLL_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (32'(pollCnt) < POLL_LIMIT)) else $error("poll counter past limit"); // R7

endmodule

// File: rtl/swbr_bridge.sv
module swbr_bridge
  import swbr_pkg::*;
#(
  parameter int ADDR_W     = 18,
  parameter int POLL_LIMIT = 1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [31:0]       reqData,
  input  logic [4:0]        reqPhyAddr,
  input  logic [4:0]        reqPhyReg,
  output logic              reqReady,
  output logic              ack,
  output logic [31:0]       rdData,
  output logic              timeoutErr,
  output logic              mdStart,
  output logic              mdWrite,
  output logic [4:0]        mdPhy,
  output logic [4:0]        mdReg,
  output logic [15:0]       mdWdata,
  input  logic              mdDone,
  input  logic [15:0]       mdRdata
);

  bridgeCtl_t ctl;
  opKind_t    opIn;
  logic       hiBusy;
  logic       pollLast;

  assign opIn = opKind_t'(reqOp);

  swbr_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqOp      (opIn),
    .mdDone     (mdDone),
    .hiBusy     (hiBusy),
    .pollLast   (pollLast),
    .ctl        (ctl),
    .reqReady   (reqReady),
    .ack        (ack),
    .timeoutErr (timeoutErr)
  );

  swbr_dp #(
    .ADDR_W     (ADDR_W),
    .POLL_LIMIT (POLL_LIMIT)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .reqOp      (opIn),
    .reqAddr    (reqAddr),
    .reqData    (reqData),
    .reqPhyAddr (reqPhyAddr),
    .reqPhyReg  (reqPhyReg),
    .mdRdata    (mdRdata),
    .hiBusy     (hiBusy),
    .pollLast   (pollLast),
    .mdStart    (mdStart),
    .mdWrite    (mdWrite),
    .mdPhy      (mdPhy),
    .mdReg      (mdReg),
    .mdWdata    (mdWdata),
    .rdData     (rdData)
  );

  AST_NO_START_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !mdStart) else $error("MDIO start while idle"); // R8

endmodule

// File: tb/sim_swbr_bridge.sv
`timescale 1ns/1ps
module sim_swbr_bridge;

  localparam int ADDR_W = 18;
  localparam int POLL_LIMIT = 1000;
  localparam int LOG_N = 128;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic              reqValid = 1'b0;
  logic [1:0]        reqOp = '0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [31:0]       reqData = '0;
  logic [4:0]        reqPhyAddr = '0;
  logic [4:0]        reqPhyReg = '0;
  logic              reqReady, ack, timeoutErr;
  logic [31:0]       rdData;
  logic              mdStart, mdWrite;
  logic [4:0]        mdPhy, mdReg;
  logic [15:0]       mdWdata;
  logic              mdDone = 1'b0;
  logic [15:0]       mdRdata = '0;

  swbr_bridge #(.ADDR_W(ADDR_W), .POLL_LIMIT(POLL_LIMIT)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp), .reqAddr(reqAddr),
    .reqData(reqData), .reqPhyAddr(reqPhyAddr), .reqPhyReg(reqPhyReg),
    .reqReady(reqReady), .ack(ack), .rdData(rdData), .timeoutErr(timeoutErr),
    .mdStart(mdStart), .mdWrite(mdWrite), .mdPhy(mdPhy), .mdReg(mdReg),
    .mdWdata(mdWdata), .mdDone(mdDone), .mdRdata(mdRdata)
  );

  int checks = 0;
  int errors = 0;

  // MDIO responder model state
  logic [15:0] salt = 16'h0000;
  int unsigned busyLimit = 0;
  int unsigned mbCnt = 0, mbBase = 0;
  int unsigned logTotal = 0, logBase = 0;
  int unsigned protoErr = 0;
  int unsigned lat = 0;
  logic [15:0] pendData = '0;
  logic        logW [LOG_N];
  logic [4:0]  logP [LOG_N];
  logic [4:0]  logR [LOG_N];
  logic [15:0] logD [LOG_N];

  logic        expW [LOG_N];
  logic [4:0]  expP [LOG_N];
  logic [4:0]  expR [LOG_N];
  logic [15:0] expD [LOG_N];
  int unsigned expTotal = 0;

  function automatic logic [15:0] halfVal(input logic [4:0] p, input logic [4:0] r);
    if (p == 5'h12 && r == 5'h0D) return salt & 16'h7fff;
    return {p, r, 6'b0} ^ salt;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mdDone <= 1'b0;
      lat = 0;
    end else begin
      mdDone <= 1'b0;
      if (mdStart) begin
        int unsigned idx;
        logic [15:0] rv;
        if (lat != 0) protoErr++;
        idx = logTotal - logBase;
        if (idx < LOG_N) begin
          logW[idx] = mdWrite; logP[idx] = mdPhy; logR[idx] = mdReg; logD[idx] = mdWdata;
        end
        logTotal++;
        rv = halfVal(mdPhy, mdReg);
        if (!mdWrite && mdPhy == 5'h12 && mdReg == 5'h0D) begin
          if ((mbCnt - mbBase) < busyLimit) rv = rv | 16'h8000;
          mbCnt++;
        end
        pendData = rv;
        lat = 1 + ($urandom % 3);
      end else if (lat != 0) begin
        lat = lat - 1;
        if (lat == 0) begin
          mdDone  <= 1'b1;
          mdRdata <= pendData;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic pushExp(input logic w, input logic [4:0] p, input logic [4:0] r, input logic [15:0] d);
    if (expTotal < LOG_N) begin
      expW[expTotal] = w; expP[expTotal] = p; expR[expTotal] = r; expD[expTotal] = d;
    end
    expTotal++;
  endtask

  task automatic expAccess(input int unsigned a, input logic w, input logic [31:0] d);
    logic [4:0] ph;
    logic [4:0] rg;
    logic [15:0] pg;
    ph = 5'(((a >> 6) & 7) | 16);
    rg = 5'((a >> 1) & 'h1e);
    pg = 16'(a >> 9);
    pushExp(1'b1, 5'h18, 5'h00, pg);
    if (!w) begin
      pushExp(1'b0, ph, rg, 16'h0);
      pushExp(1'b0, ph, rg | 5'd1, 16'h0);
    end else if (a == 'h98) begin
      pushExp(1'b1, ph, rg, d[15:0]);
      pushExp(1'b1, ph, rg | 5'd1, d[31:16]);
    end else begin
      pushExp(1'b1, ph, rg | 5'd1, d[31:16]);
      pushExp(1'b1, ph, rg, d[15:0]);
    end
  endtask

  task automatic compareLog(input string req);
    int unsigned got;
    int unsigned lim;
    got = logTotal - logBase;
    chk(got == expTotal, req, "MDIO command count", got, expTotal);
    lim = (got < expTotal) ? got : expTotal;
    if (lim > LOG_N) lim = LOG_N;
    for (int i = 0; i < int'(lim); i++) begin
      logic ok;
      ok = (logW[i] == expW[i]) && (logP[i] == expP[i]) && (logR[i] == expR[i]) &&
           (!expW[i] || logD[i] == expD[i]);
      chk(ok, req, $sformatf("MDIO command %0d {w,phy,reg,data}", i),
          {5'b0, logW[i], logP[i], logR[i], logD[i]}, {5'b0, expW[i], expP[i], expR[i], expD[i]});
    end
  endtask

  task automatic runOp(input logic [1:0] op, input int unsigned a, input logic [31:0] d,
                       input logic [4:0] pa, input logic [4:0] pr,
                       output logic [31:0] res, output logic err, output bit gotAck);
    int n;
    @(negedge clk);
    logBase = logTotal;
    mbBase = mbCnt;
    reqOp = op; reqAddr = ADDR_W'(a); reqData = d; reqPhyAddr = pa; reqPhyReg = pr;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    n = 0; gotAck = 0;
    while (n < 40000) begin
      if (ack) begin gotAck = 1; break; end
      @(negedge clk);
      n++;
    end
    res = rdData;
    err = timeoutErr;
  endtask

  task automatic regRead(input int unsigned a, input string req);
    logic [31:0] res; logic err; bit got;
    logic [4:0] ph; logic [4:0] rg;
    salt = 16'($urandom);
    busyLimit = 0;
    runOp(2'd0, a, 32'h0, 5'd0, 5'd0, res, err, got);
    ph = 5'(((a >> 6) & 7) | 16);
    rg = 5'((a >> 1) & 'h1e);
    expTotal = 0;
    expAccess(a, 1'b0, 32'h0);
    chk(got, req, "read ack", 32'(got), 32'd1);
    chk(res == {halfVal(ph, rg | 5'd1), halfVal(ph, rg)}, req, "read data",
        res, {halfVal(ph, rg | 5'd1), halfVal(ph, rg)});
    chk(err == 1'b0, req, "no timeout", 32'(err), 32'd0);
    compareLog(req);
  endtask

  task automatic regWrite(input int unsigned a, input logic [31:0] d, input string req);
    logic [31:0] res; logic err; bit got;
    salt = 16'($urandom);
    busyLimit = 0;
    runOp(2'd1, a, d, 5'd0, 5'd0, res, err, got);
    expTotal = 0;
    expAccess(a, 1'b1, d);
    chk(got, req, "write ack", 32'(got), 32'd1);
    compareLog(req);
  endtask

  task automatic phyOp(input bit rd, input logic [4:0] pa, input logic [4:0] pr,
                       input logic [15:0] d, input int unsigned k, input string req);
    logic [31:0] res; logic err; bit got;
    logic [31:0] mbox;
    salt = 16'($urandom);
    busyLimit = k + 1;
    runOp(rd ? 2'd2 : 2'd3, 'h98, {16'h0, d}, pa, pr, res, err, got);
    mbox = {4'b1100, rd, 1'b0, pa, pr, rd ? 16'h0 : d};
    expTotal = 0;
    expAccess('h98, 1'b0, 32'h0);
    expAccess('h98, 1'b1, mbox);
    for (int i = 0; i <= int'(k); i++) expAccess('h98, 1'b0, 32'h0);
    chk(got, req, "PHY op ack", 32'(got), 32'd1);
    chk(err == 1'b0, req, "no timeout", 32'(err), 32'd0);
    chk(res == {16'h0, halfVal(5'h12, 5'h0C)}, req, "PHY result", res, {16'h0, halfVal(5'h12, 5'h0C)});
    compareLog(req);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] res; logic err; bit got;
    int unsigned t0;
    int ackCnt;
    void'($urandom(32'd20240611));

    repeat (3) @(negedge clk);
    chk(reqReady == 1'b1, "R9", "ready in reset", 32'(reqReady), 32'd1);
    chk(ack == 1'b0, "R9", "ack in reset", 32'(ack), 32'd0);
    chk(mdStart == 1'b0, "R9", "start in reset", 32'(mdStart), 32'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(reqReady == 1'b1 && ack == 1'b0 && mdStart == 1'b0, "R9", "idle after reset",
        {29'b0, reqReady, ack, mdStart}, 32'h4);

    regRead('h1A4C, "R1");
    regRead('h3FFFC, "R1");
    regWrite('h0624, 32'h7f7f7f7f, "R2");
    regWrite('h0038, 32'hc000050e, "R2");
    regWrite('h0098, 32'h12345678, "R3");
    phyOp(1'b1, 5'd4, 5'd1, 16'h0, 0, "R4");
    phyOp(1'b1, 5'd3, 5'd2, 16'h0, 3, "R6");
    phyOp(1'b0, 5'd1, 5'd0, 16'h9000, 2, "R5");

    // R8: request while busy is ignored
    salt = 16'h5a5a; busyLimit = 0;
    @(negedge clk);
    logBase = logTotal;
    reqOp = 2'd0; reqAddr = ADDR_W'('h0104); reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    repeat (3) @(negedge clk);
    chk(reqReady == 1'b0, "R8", "not ready while busy", 32'(reqReady), 32'd0);
    reqOp = 2'd1; reqAddr = ADDR_W'('h0200); reqData = 32'hdeadbeef; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    ackCnt = 0;
    for (int n = 0; n < 200; n++) begin
      if (ack) ackCnt++;
      @(negedge clk);
    end
    expTotal = 0;
    expAccess('h0104, 1'b0, 32'h0);
    chk(ackCnt == 1, "R8", "exactly one ack", 32'(ackCnt), 32'd1);
    chk(rdData == {halfVal(5'h14, 5'h03), halfVal(5'h14, 5'h02)}, "R8", "first request data",
        rdData, {halfVal(5'h14, 5'h03), halfVal(5'h14, 5'h02)});
    compareLog("R8");

    for (int i = 0; i < 24; i++) begin
      int unsigned a;
      a = $urandom % (1 << ADDR_W);
      if (($urandom % 2) == 0) begin
        if (a == 'h98) a = 'h9C;
        regRead(a, "R1");
      end else begin
        if (($urandom % 4) == 0) a = 'h98;
        regWrite(a, $urandom, (a == 'h98) ? "R3" : "R2");
      end
    end
    for (int i = 0; i < 4; i++) begin
      phyOp(($urandom % 2) == 1, 5'($urandom), 5'($urandom), 16'($urandom), $urandom % 6, "R6");
    end

    // R7: mailbox never goes idle
    salt = 16'h0f0f;
    busyLimit = 32'hffff_ffff;
    runOp(2'd2, 'h98, 32'h0, 5'd2, 5'd3, res, err, got);
    expTotal = 0;
    expAccess('h98, 1'b0, 32'h0);
    expAccess('h98, 1'b1, {4'b1100, 1'b1, 1'b0, 5'd2, 5'd3, 16'h0});
    for (int i = 0; i < POLL_LIMIT; i++) expAccess('h98, 1'b0, 32'h0);
    chk(got, "R7", "timeout ack", 32'(got), 32'd1);
    chk(err == 1'b1, "R7", "timeout flag", 32'(err), 32'd1);
    compareLog("R7");
    t0 = logTotal;
    repeat (20) @(negedge clk);
    chk(logTotal == t0, "R7", "no command after timeout", logTotal, t0);
    chk(reqReady == 1'b1, "R8", "ready after timeout", 32'(reqReady), 32'd1);

    chk(protoErr == 0, "R10", "start while command outstanding", protoErr, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule